// File: doc/BRIEF.md
# Timer Fault and Run-State Controller

This block keeps the fault and run status of a timer/counter. It watches two groups of fault inputs. Faults in the non-recoverable group are held until software clears them. Faults in the recoverable group are also released by a resume event. The block also tracks a fault raised on debug entry and a fault raised when the ramp index changes while updates are locked. It holds the ramp cycle index and the stopped/running flag.

From these states the block drives two requests to the counter and waveform logic around it. The first is a halt request that freezes counting. The second asks for the non-recoverable safe output state. It also gives a one-cycle signal that tells the counter to restart from bottom instead of from its held value. The counting itself and the waveform drive values belong to the surrounding logic.

Top module: `tmr_fault_stop_ctrl`

## Requirements
- R1: A non-recoverable fault state bit is set one clock after its input is high, and it stays set while the input remains high.
- R2: A write-one-to-clear strobe clears a non-recoverable fault state bit only in a cycle when that bit's input is low. While any non-recoverable state bit is set, both `halt_o` and `safe_o` are high.
- R3: A `restart_i` pulse may arrive while a non-recoverable state is held. In that case `resume_bottom_o` is high for exactly one cycle: the first cycle in which no non-recoverable state is set. Without such a pulse, `resume_bottom_o` stays low.
- R4: A recoverable fault state bit is set one clock after its input is high. It is cleared by `resume_i`, or by its clear strobe while its input is low. A high input wins over either clear.
- R5: While `sw_halt_i` is high and any recoverable state bit is set, `halt_o` is high. Recoverable states never raise `safe_o`.
- R6: `nrf_live_o` and `rf_live_o` equal the fault inputs in the same cycle, without a clock delay.
- R7: The debug fault flag is set one clock after `dbg_mode_i` and `dbg_fault_en_i` are both high. Its clear strobe has effect only while `dbg_mode_i` is low. While the flag is set, `halt_o` and `safe_o` are high.
- R8: The update fault flag is set on the clock where the ramp index changes while `lock_upd_i` is high. It is cleared by its strobe, and a new set wins over the strobe. While it is set, `safe_o` is high and `halt_o` is not raised by it.
- R9: When `ramp_two_i`=1, the ramp index toggles on each `ramp_adv_i` (0 = cycle A, 1 = cycle B). When `ramp_two_i`=0, `ramp_idx_o` reads 0 and the index never changes.
- R10: The stop flag is set by `stop_cmd_i`, or by `update_i` while `one_shot_i` is high. It is cleared by `step_i`. A set wins over a step in the same cycle.
- R11: After reset, every state output is 0 except `stop_o`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nrf_in_i | input | 2 | Non-recoverable fault inputs |
| rf_in_i | input | 2 | Recoverable fault inputs |
| nrf_clr_i | input | 2 | Write-one-to-clear strobes, non-recoverable states |
| rf_clr_i | input | 2 | Write-one-to-clear strobes, recoverable states |
| resume_i | input | 1 | Fault action resume event |
| sw_halt_i | input | 1 | Software-halt mode for recoverable faults |
| restart_i | input | 1 | Counter restart command |
| dbg_mode_i | input | 1 | Debug mode active |
| dbg_fault_en_i | input | 1 | Raise fault on debug entry |
| dbg_clr_i | input | 1 | Clear strobe, debug fault flag |
| ramp_two_i | input | 1 | 1 = two-cycle ramp, 0 = single-cycle ramp |
| ramp_adv_i | input | 1 | Ramp cycle advance |
| lock_upd_i | input | 1 | Lock-update setting |
| upd_clr_i | input | 1 | Clear strobe, update fault flag |
| stop_cmd_i | input | 1 | Stop command |
| update_i | input | 1 | Update event |
| one_shot_i | input | 1 | One-shot mode |
| step_i | input | 1 | Counter increment/decrement pulse |
| nrf_state_o | output | 2 | Latched non-recoverable fault states |
| rf_state_o | output | 2 | Latched recoverable fault states |
| nrf_live_o | output | 2 | Live non-recoverable fault inputs |
| rf_live_o | output | 2 | Live recoverable fault inputs |
| dbg_fault_o | output | 1 | Debug fault flag |
| upd_fault_o | output | 1 | Update fault flag |
| ramp_idx_o | output | 1 | Ramp index |
| stop_o | output | 1 | Stop flag |
| halt_o | output | 1 | Counter halt request |
| safe_o | output | 1 | Force safe output state request |
| resume_bottom_o | output | 1 | Restart-from-bottom pulse |

## Verification
Every latched state (fault bits, debug and update flags, ramp index, stop flag) changes at the first clock edge after its cause. The bench therefore drives a stimulus just after one edge and reads the state just after the next. The live mirrors, `ramp_idx_o` gating, `halt_o` and `safe_o` are combinational from inputs and registered state, so they are read in the same cycle as the input that moves them. `resume_bottom_o` is read on the cycle right after the edge that clears the last non-recoverable state, and again one cycle later to confirm that the pulse has ended.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    localparam int unsigned NRF_N = 2;
    localparam int unsigned RF_N  = 2;

    typedef struct packed {
        logic dbg;
        logic upd;
        logic ramp;
        logic stop;
    } run_state_t;

    typedef struct packed {
        logic pend;
    } restart_state_t;
endpackage

// File: rtl/tfs_fault_bank.sv
module tfs_fault_bank #(
    parameter int unsigned N       = 2,
    parameter bit          RECOVER = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] fault_i,
    input  logic [N-1:0] clr_i,
    input  logic         resume_i,
    output logic [N-1:0] state_o
);
    typedef struct packed {
        logic [N-1:0] st;
    } bank_t;

    bank_t        bank_d, bank_q;
    logic [N-1:0] drop;

    generate
        if (RECOVER) begin : g_rec
            assign drop = (clr_i & ~fault_i) | {N{resume_i}};
        end else begin : g_nrec
            assign drop = clr_i & ~fault_i;
        end
    endgenerate

    always_comb begin
        bank_d    = bank_q;
        bank_d.st = fault_i | (bank_q.st & ~drop);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign state_o = bank_q.st;
endmodule

// File: rtl/tfs_run_state.sv
module tfs_run_state
    import tfs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dbg_mode_i,
    input  logic dbg_fault_en_i,
    input  logic dbg_clr_i,
    input  logic ramp_two_i,
    input  logic ramp_adv_i,
    input  logic lock_upd_i,
    input  logic upd_clr_i,
    input  logic stop_cmd_i,
    input  logic update_i,
    input  logic one_shot_i,
    input  logic step_i,
    output logic dbg_fault_o,
    output logic upd_fault_o,
    output logic ramp_idx_o,
    output logic stop_o
);
    run_state_t rs_d, rs_q;
    logic       ramp_flip;
    logic       halt_cause;

    assign ramp_flip  = ramp_two_i & ramp_adv_i;
    assign halt_cause = stop_cmd_i | (update_i & one_shot_i);

    always_comb begin
        rs_d = rs_q;
        // debug fault: write-one clear only outside debug mode
        if (dbg_mode_i && dbg_fault_en_i)  rs_d.dbg = 1'b1;
        else if (dbg_clr_i && !dbg_mode_i) rs_d.dbg = 1'b0;
        // ramp index: held at cycle A in single-cycle mode
        if (!ramp_two_i)     rs_d.ramp = 1'b0;
        else if (ramp_flip)  rs_d.ramp = ~rs_q.ramp;
        // update fault: index change under lock
        if (ramp_flip && lock_upd_i) rs_d.upd = 1'b1;
        else if (upd_clr_i)          rs_d.upd = 1'b0;
        // stop flag: set dominates step
        if (halt_cause)  rs_d.stop = 1'b1;
        else if (step_i) rs_d.stop = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rs_q <= '{dbg: 1'b0, upd: 1'b0, ramp: 1'b0, stop: 1'b1};
        else         rs_q <= rs_d;
    end

    assign dbg_fault_o = rs_q.dbg;
    assign upd_fault_o = rs_q.upd;
    assign ramp_idx_o  = rs_q.ramp & ramp_two_i;
    assign stop_o      = rs_q.stop;
endmodule

// File: rtl/tfs_restart_track.sv
module tfs_restart_track
    import tfs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic held_i,
    input  logic restart_i,
    output logic bottom_o
);
    restart_state_t rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (held_i) rt_d.pend = rt_q.pend | restart_i;
        else        rt_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rt_q <= '0;
        else         rt_q <= rt_d;
    end

    assign bottom_o = rt_q.pend & ~held_i;
endmodule

// File: rtl/tmr_fault_stop_ctrl.sv
module tmr_fault_stop_ctrl
    import tfs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NRF_N-1:0]  nrf_in_i,
    input  logic [RF_N-1:0]   rf_in_i,
    input  logic [NRF_N-1:0]  nrf_clr_i,
    input  logic [RF_N-1:0]   rf_clr_i,
    input  logic              resume_i,
    input  logic              sw_halt_i,
    input  logic              restart_i,
    input  logic              dbg_mode_i,
    input  logic              dbg_fault_en_i,
    input  logic              dbg_clr_i,
    input  logic              ramp_two_i,
    input  logic              ramp_adv_i,
    input  logic              lock_upd_i,
    input  logic              upd_clr_i,
    input  logic              stop_cmd_i,
    input  logic              update_i,
    input  logic              one_shot_i,
    input  logic              step_i,
    output logic [NRF_N-1:0]  nrf_state_o,
    output logic [RF_N-1:0]   rf_state_o,
    output logic [NRF_N-1:0]  nrf_live_o,
    output logic [RF_N-1:0]   rf_live_o,
    output logic              dbg_fault_o,
    output logic              upd_fault_o,
    output logic              ramp_idx_o,
    output logic              stop_o,
    output logic              halt_o,
    output logic              safe_o,
    output logic              resume_bottom_o
);
    logic [NRF_N-1:0] nrf_st;
    logic [RF_N-1:0]  rf_st;
    logic             dbg_st, upd_st, nrf_any;

    tfs_fault_bank #(.N(NRF_N), .RECOVER(1'b0)) i_nrf_bank (
        .clk_i, .rst_ni,
        .fault_i (nrf_in_i),
        .clr_i   (nrf_clr_i),
        .resume_i(1'b0),
        .state_o (nrf_st)
    );

    tfs_fault_bank #(.N(RF_N), .RECOVER(1'b1)) i_rf_bank (
        .clk_i, .rst_ni,
        .fault_i (rf_in_i),
        .clr_i   (rf_clr_i),
        .resume_i(resume_i),
        .state_o (rf_st)
    );

    tfs_run_state i_run (
        .clk_i, .rst_ni,
        .dbg_mode_i, .dbg_fault_en_i, .dbg_clr_i,
        .ramp_two_i, .ramp_adv_i, .lock_upd_i, .upd_clr_i,
        .stop_cmd_i, .update_i, .one_shot_i, .step_i,
        .dbg_fault_o(dbg_st),
        .upd_fault_o(upd_st),
        .ramp_idx_o,
        .stop_o
    );

    assign nrf_any = |nrf_st;

    tfs_restart_track i_restart (
        .clk_i, .rst_ni,
        .held_i   (nrf_any),
        .restart_i(restart_i),
        .bottom_o (resume_bottom_o)
    );

    assign nrf_state_o = nrf_st;
    assign rf_state_o  = rf_st;
    assign nrf_live_o  = nrf_in_i;
    assign rf_live_o   = rf_in_i;
    assign dbg_fault_o = dbg_st;
    assign upd_fault_o = upd_st;
    assign halt_o      = nrf_any | dbg_st | (sw_halt_i & (|rf_st));
    assign safe_o      = nrf_any | dbg_st | upd_st;
endmodule

// File: rtl/tfs_checker.sv
module tfs_checker
    import tfs_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [NRF_N-1:0] nrf_in_i,
    input logic [RF_N-1:0]  rf_in_i,
    input logic             dbg_mode_i,
    input logic             dbg_fault_en_i,
    input logic             ramp_two_i,
    input logic             ramp_adv_i,
    input logic             lock_upd_i,
    input logic             stop_cmd_i,
    input logic             update_i,
    input logic             one_shot_i,
    input logic             step_i,
    input logic [NRF_N-1:0] nrf_state_o,
    input logic [RF_N-1:0]  rf_state_o,
    input logic             dbg_fault_o,
    input logic             upd_fault_o,
    input logic             stop_o,
    input logic             halt_o,
    input logic             safe_o
);
    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    AST_NRF_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> ((nrf_state_o & $past(nrf_in_i)) == $past(nrf_in_i))); // R1
    AST_NRF_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nrf_state_o != '0) |-> (halt_o && safe_o)); // R2
    AST_RF_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> ((rf_state_o & $past(rf_in_i)) == $past(rf_in_i))); // R4
    AST_DBG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_mode_i && dbg_fault_en_i) |=> (dbg_fault_o && halt_o)); // R7
    AST_UPD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ramp_two_i && ramp_adv_i && lock_upd_i) |=> (upd_fault_o && safe_o)); // R8
    AST_STOP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !stop_cmd_i && !(update_i && one_shot_i)) |=> !stop_o); // R10
endmodule

bind tmr_fault_stop_ctrl tfs_checker i_tfs_checker (
    .clk_i, .rst_ni, .nrf_in_i, .rf_in_i, .dbg_mode_i, .dbg_fault_en_i,
    .ramp_two_i, .ramp_adv_i, .lock_upd_i, .stop_cmd_i, .update_i,
    .one_shot_i, .step_i, .nrf_state_o, .rf_state_o, .dbg_fault_o,
    .upd_fault_o, .stop_o, .halt_o, .safe_o
);

// File: tb/test_tmr_fault_stop_ctrl.sv
module test_tmr_fault_stop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // each entry: {nrf_in[1:0], nrf_clr[1:0], expected nrf_state[1:0]}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b01_00_01, 6'b01_01_01, 6'b00_00_01, 6'b10_01_10,
        6'b00_10_00, 6'b11_00_11, 6'b00_11_00
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] nrf_in = '0, rf_in = '0, nrf_clr = '0, rf_clr = '0;
    logic resume = 0, sw_halt = 0, restart = 0, dbg_mode = 0, dbg_en = 0, dbg_clr = 0;
    logic ramp_two = 0, ramp_adv = 0, lock_upd = 0, upd_clr = 0;
    logic stop_cmd = 0, update = 0, one_shot = 0, step = 0;
    logic [1:0] nrf_state, rf_state, nrf_live, rf_live;
    logic dbg_fault, upd_fault, ramp_idx, stop, halt, safe, bottom;
    int tests = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_fault_stop_ctrl i_tmr_fault_stop_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .nrf_in_i(nrf_in), .rf_in_i(rf_in),
        .nrf_clr_i(nrf_clr), .rf_clr_i(rf_clr), .resume_i(resume),
        .sw_halt_i(sw_halt), .restart_i(restart), .dbg_mode_i(dbg_mode),
        .dbg_fault_en_i(dbg_en), .dbg_clr_i(dbg_clr), .ramp_two_i(ramp_two),
        .ramp_adv_i(ramp_adv), .lock_upd_i(lock_upd), .upd_clr_i(upd_clr),
        .stop_cmd_i(stop_cmd), .update_i(update), .one_shot_i(one_shot),
        .step_i(step), .nrf_state_o(nrf_state), .rf_state_o(rf_state),
        .nrf_live_o(nrf_live), .rf_live_o(rf_live), .dbg_fault_o(dbg_fault),
        .upd_fault_o(upd_fault), .ramp_idx_o(ramp_idx), .stop_o(stop),
        .halt_o(halt), .safe_o(safe), .resume_bottom_o(bottom)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance one edge; inputs are then driven and outputs read 1 unit after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_pulses();
        nrf_clr = '0; rf_clr = '0; resume = 0; restart = 0; dbg_clr = 0;
        ramp_adv = 0; upd_clr = 0; stop_cmd = 0; update = 0; step = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset values
        chk("R11", {nrf_state, rf_state}, 4'h0);
        chk("R11", {dbg_fault, upd_fault, ramp_idx, stop}, 4'b0001);
        rst_n = 1;
        tick();
        chk("R11", {halt, safe, bottom, stop}, 4'b0001);

        // R1/R2: vector walk over the non-recoverable bank
        for (int i = 0; i < NVEC; i++) begin
            nrf_in = VEC[i][5:4]; nrf_clr = VEC[i][3:2];
            tick();
            chk("R1_R2 state", {2'b0, nrf_state}, {2'b0, VEC[i][1:0]});
            chk("R2 halt/safe", {2'b0, halt, safe}, {2'b0, {2{|VEC[i][1:0]}}});
        end
        nrf_in = '0; clear_pulses();

        // R6: live mirrors same cycle
        nrf_in = 2'b10; rf_in = 2'b01; #1;
        chk("R6", {nrf_live, rf_live}, 4'b1001);
        nrf_in = '0; rf_in = '0; #1;
        chk("R6", {nrf_live, rf_live}, 4'b0000);

        // R3: restart while held -> one pulse
        nrf_in = 2'b01; tick();
        restart = 1; tick(); restart = 0;
        nrf_in = '0; nrf_clr = 2'b01; tick(); nrf_clr = '0;
        chk("R3 pulse", {3'b0, bottom}, 4'h1);
        tick();
        chk("R3 end", {3'b0, bottom}, 4'h0);
        // R3: no restart -> no pulse
        nrf_in = 2'b10; tick();
        nrf_in = '0; nrf_clr = 2'b10; tick(); nrf_clr = '0;
        chk("R3 none", {2'b0, |nrf_state, bottom}, 4'h0);

        // R4/R5: recoverable bank
        rf_in = 2'b01; tick();
        chk("R4 set", {2'b0, rf_state}, 4'h1);
        chk("R5 no halt", {2'b0, halt, safe}, 4'h0);
        sw_halt = 1; #1;
        chk("R5 sw halt", {2'b0, halt, safe}, 4'b0010);
        rf_in = '0; resume = 1; tick(); resume = 0;
        chk("R4 resume", {1'b0, halt, rf_state}, 4'h0);
        rf_in = 2'b10; tick();
        rf_clr = 2'b10; tick();
        chk("R4 blocked clr", {2'b0, rf_state}, 4'b0010);
        rf_in = '0; tick(); rf_clr = '0;
        chk("R4 clr", {2'b0, rf_state}, 4'h0);
        rf_in = 2'b01; resume = 1; tick(); resume = 0; rf_in = '0;
        chk("R4 set wins", {2'b0, rf_state}, 4'h1);
        resume = 1; tick(); resume = 0; sw_halt = 0;

        // R7: debug fault
        dbg_mode = 1; tick();
        chk("R7 no enable", {3'b0, dbg_fault}, 4'h0);
        dbg_en = 1; tick();
        chk("R7 set", {1'b0, dbg_fault, halt, safe}, 4'b0111);
        dbg_en = 0; dbg_clr = 1; tick();
        chk("R7 clr in debug", {3'b0, dbg_fault}, 4'h1);
        dbg_mode = 0; tick(); dbg_clr = 0;
        chk("R7 clr", {1'b0, dbg_fault, halt, safe}, 4'h0);

        // R9/R8: ramp index and update fault
        lock_upd = 1; ramp_adv = 1; tick();
        chk("R9 single", {2'b0, ramp_idx, upd_fault}, 4'h0);
        lock_upd = 0; ramp_two = 1; tick();
        chk("R9 cycle B", {2'b0, ramp_idx, upd_fault}, 4'b0010);
        lock_upd = 1; tick(); ramp_adv = 0;
        chk("R9_R8 lock", {ramp_idx, upd_fault, halt, safe}, 4'b0101);
        lock_upd = 0; upd_clr = 1; tick(); upd_clr = 0;
        chk("R8 clr", {2'b0, upd_fault, safe}, 4'h0);
        ramp_adv = 1; tick(); ramp_adv = 0;
        ramp_two = 0; #1;
        chk("R9 gate", {3'b0, ramp_idx}, 4'h0);

        // R10: stop flag
        step = 1; tick(); step = 0;
        chk("R10 step", {3'b0, stop}, 4'h0);
        stop_cmd = 1; tick(); stop_cmd = 0;
        chk("R10 cmd", {3'b0, stop}, 4'h1);
        step = 1; tick(); step = 0;
        update = 1; tick();
        chk("R10 update no oneshot", {3'b0, stop}, 4'h0);
        one_shot = 1; tick(); update = 0; one_shot = 0;
        chk("R10 oneshot", {3'b0, stop}, 4'h1);
        step = 1; tick();
        step = 1; stop_cmd = 1; tick(); clear_pulses();
        chk("R10 set wins", {3'b0, stop}, 4'h1);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        #2;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule